// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor core whose calling convention slides a window over a large physical store. At any moment software names 32 registers: eight globals shared by every procedure and 24 taken from the current window. Those 24 are split into three groups of eight: outgoing, private (local), and incoming. A window shares its outgoing group with the next deeper window and its incoming group with the next shallower one. Arguments written into the outgoing group therefore appear in the callee's incoming group without any copy.

Two combinational read ports and one write port address the file by architectural number. A translation stage maps each number to a physical entry using the current-window pointer. A save strobe moves the pointer one step down, with wrap, and a restore strobe moves it one step back up. A depth counter tracks outstanding saved frames. A save that would run into a frame still in use, or a restore with nothing to return to, is refused and reported on a one-cycle flag. Spilling and filling frames is the job of the surrounding trap logic.

The number of windows is a parameter from 3 to 32. The physical store holds 8 + 16 × NWIN entries.

Top module: `win_regfile`

## Requirements
- R1: Architectural numbers decode by their top two bits: 0–7 are globals, 8–15 outgoing, 16–23 local and 24–31 incoming. Both read ports return data in the same cycle as their address.
- R2: Register 0 always reads as zero. A write to it has no effect and is never forwarded to a reader.
- R3: Globals 1–7 are the same physical registers in every window.
- R4: A save moves the pointer from w to (w−1) mod NWIN. The outgoing register k seen before the save is seen as incoming register k (number 24+k) after it.
- R5: Each window's eight locals are private: a write to a local in one window leaves the locals of every other window unchanged.
- R6: A restore moves the pointer from w to (w+1) mod NWIN. The caller's locals and outgoing registers read back the values they held before the matching save.
- R7: When NWIN−2 saved frames are outstanding, a save is refused. The pointer does not move and the overflow output is high for exactly the following cycle.
- R8: When no saved frame is outstanding, a restore is refused. The pointer does not move and the underflow output is high for exactly the following cycle.
- R9: A synchronous reset sets the pointer to 0, the depth to 0, both flags low and every register to zero.
- R10: When a read and the write address the same physical register in the same cycle, the read returns the value being written.
- R11: Save and restore asserted together are ignored: the pointer is unchanged and neither flag rises.
- R12: A write issued in the same cycle as a save or restore uses the window in force before the pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 5 | Read port A architectural number |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_addr | input | 5 | Read port B architectural number |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural number |
| wr_data | input | XLEN | Write data |
| call_save | input | 1 | Move to the next deeper window |
| ret_restore | input | 1 | Move back to the shallower window |
| cwp | output | $clog2(NWIN) | Current-window pointer |
| win_overflow | output | 1 | Refused save, one-cycle pulse |
| win_underflow | output | 1 | Refused restore, one-cycle pulse |

## Verification
Directed sequences place a known value in each register group and then move the window. Reading the outgoing value back as incoming, the private value as zero in the callee, and the global as unchanged separates a correct overlap from an off-by-one mapping or a shared local group. Runs of saves to the depth limit, and restores from an empty stack, tell a refused move apart from a wrapped one. Same-address read/write pairs, including register 0, tell forwarding from stale data. A long pseudo-random mix of saves, restores and writes to every group is then compared on every clock against a behavioural model built from frame arrays.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int ARCH_REGS  = 32;
    localparam int GROUP_SIZE = 8;
    localparam int WIN_SPAN   = 2 * GROUP_SIZE;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'b00,
        GRP_OUT    = 2'b01,
        GRP_LOCAL  = 2'b10,
        GRP_IN     = 2'b11
    } reg_group_e;

    typedef enum logic [1:0] {
        WOP_NONE    = 2'b00,
        WOP_SAVE    = 2'b01,
        WOP_RESTORE = 2'b10
    } win_op_e;

    function automatic reg_group_e group_of(input logic [4:0] arch);
        return reg_group_e'(arch[4:3]);
    endfunction

    function automatic win_op_e decode_op(input logic save, input logic restore);
        if (save && !restore)  return WOP_SAVE;
        if (restore && !save)  return WOP_RESTORE;
        return WOP_NONE;
    endfunction

endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 3,
    parameter int PW   = 8
) (
    input  logic [CW-1:0] cur_win,
    input  logic [4:0]    arch,
    output logic [PW-1:0] phys,
    output logic          is_zero
);

    int prev_win;
    int base_idx;

    always_comb begin
        prev_win = (int'(cur_win) == 0) ? NWIN - 1 : int'(cur_win) - 1;
        unique case (group_of(arch))
            GRP_GLOBAL: base_idx = 0;
            GRP_OUT:    base_idx = GROUP_SIZE + WIN_SPAN * prev_win + GROUP_SIZE;
            GRP_LOCAL:  base_idx = GROUP_SIZE + WIN_SPAN * int'(cur_win);
            default:    base_idx = GROUP_SIZE + WIN_SPAN * int'(cur_win) + GROUP_SIZE;
        endcase
        phys    = PW'(base_idx + int'(arch[2:0]));
        is_zero = (arch == 5'd0);
    end

endmodule

// File: rtl/wrf_winctl.sv
module wrf_winctl
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          save,
    input  logic          restore,
    output logic [CW-1:0] cur_win,
    output logic          ovf,
    output logic          unf
);

    localparam int DW = $clog2(NWIN);
    localparam logic [DW-1:0] MAX_DEPTH = DW'(NWIN - 2);
    localparam logic [CW-1:0] LAST_WIN  = CW'(NWIN - 1);

    logic [DW-1:0] depth;
    win_op_e       op;
    logic [CW-1:0] win_down;
    logic [CW-1:0] win_up;

    always_comb begin
        op       = decode_op(save, restore);
        win_down = (cur_win == '0) ? LAST_WIN : cur_win - 1'b1;
        win_up   = (cur_win == LAST_WIN) ? '0 : cur_win + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_win <= '0;
            depth   <= '0;
            ovf     <= 1'b0;
            unf     <= 1'b0;
        end else begin
            ovf <= 1'b0;
            unf <= 1'b0;
            unique case (op)
                WOP_SAVE: begin
                    if (depth == MAX_DEPTH) begin
                        ovf <= 1'b1;
                    end else begin
                        cur_win <= win_down;
                        depth   <= depth + 1'b1;
                    end
                end
                WOP_RESTORE: begin
                    if (depth == '0) begin
                        unf <= 1'b1;
                    end else begin
                        cur_win <= win_up;
                        depth   <= depth - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
    parameter int XLEN  = 32,
    parameter int NPHYS = 136,
    parameter int PW    = 8,
    parameter int NRD   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [PW-1:0]             wphys,
    input  logic                      wzero,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][PW-1:0]    rphys,
    input  logic [NRD-1:0]            rzero,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);

    logic [XLEN-1:0] mem [NPHYS];
    logic            wr_live;

    assign wr_live = we && !wzero;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_live) begin
            mem[wphys] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [XLEN-1:0] val;
        always_comb begin
            if (rzero[g]) begin
                val = '0;
            end else if (wr_live && (wphys == rphys[g])) begin
                val = wdata;
            end else begin
                val = mem[rphys[g]];
            end
        end
        assign rdata[g] = val;
    end

endmodule

// File: rtl/win_regfile.sv
module win_regfile
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      rd_a_addr,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [4:0]      rd_b_addr,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            call_save,
    input  logic            ret_restore,
    output logic [CW-1:0]   cwp,
    output logic            win_overflow,
    output logic            win_underflow
);

    localparam int NPHYS = GROUP_SIZE + WIN_SPAN * NWIN;
    localparam int PW    = $clog2(NPHYS);
    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;
    localparam int WPORT = NRD;

    logic [NPORT-1:0][4:0]    port_arch;
    logic [NPORT-1:0][PW-1:0] port_phys;
    logic [NPORT-1:0]         port_zero;
    logic [NRD-1:0][XLEN-1:0] rd_vals;
    logic [CW-1:0]            cur_win;

    assign port_arch[0]     = rd_a_addr;
    assign port_arch[1]     = rd_b_addr;
    assign port_arch[WPORT] = wr_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_xl
        wrf_xlate #(
            .NWIN (NWIN),
            .CW   (CW),
            .PW   (PW)
        ) u_xlate (
            .cur_win (cur_win),
            .arch    (port_arch[p]),
            .phys    (port_phys[p]),
            .is_zero (port_zero[p])
        );
    end

    wrf_winctl #(
        .NWIN (NWIN),
        .CW   (CW)
    ) u_winctl (
        .clk     (clk),
        .rst     (rst),
        .save    (call_save),
        .restore (ret_restore),
        .cur_win (cur_win),
        .ovf     (win_overflow),
        .unf     (win_underflow)
    );

    wrf_store #(
        .XLEN  (XLEN),
        .NPHYS (NPHYS),
        .PW    (PW),
        .NRD   (NRD)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .wphys (port_phys[WPORT]),
        .wzero (port_zero[WPORT]),
        .wdata (wr_data),
        .rphys (port_phys[NRD-1:0]),
        .rzero (port_zero[NRD-1:0]),
        .rdata (rd_vals)
    );

    assign rd_a_data = rd_vals[0];
    assign rd_b_data = rd_vals[1];
    assign cwp       = cur_win;

endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int CW   = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [4:0]      rd_a_addr,
    input logic [XLEN-1:0] rd_a_data,
    input logic [4:0]      rd_b_addr,
    input logic [XLEN-1:0] rd_b_data,
    input logic            call_save,
    input logic            ret_restore,
    input logic [CW-1:0]   cwp,
    input logic            win_overflow,
    input logic            win_underflow
);

    localparam logic [CW-1:0] LAST_WIN = CW'(NWIN - 1);

    // R2: register 0 reads zero on both ports
    assert_zero_read_a_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == 5'd0) |-> (rd_a_data == '0));
    assert_zero_read_b_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == 5'd0) |-> (rd_b_data == '0));

    // R4: pointer stays inside the implemented windows
    assert_cwp_range_R4: assert property (@(posedge clk) disable iff (rst)
        cwp <= LAST_WIN);

    // R4: an accepted save steps down by one with wrap
    assert_save_step_R4: assert property (@(posedge clk) disable iff (rst)
        (call_save && !ret_restore) |=> (win_overflow ||
            cwp == (($past(cwp) == '0) ? LAST_WIN : $past(cwp) - 1'b1)));

    // R6: an accepted restore steps up by one with wrap
    assert_restore_step_R6: assert property (@(posedge clk) disable iff (rst)
        (ret_restore && !call_save) |=> (win_underflow ||
            cwp == (($past(cwp) == LAST_WIN) ? '0 : $past(cwp) + 1'b1)));

    // R7: a refused save leaves the pointer in place
    assert_no_overflow_move_R7: assert property (@(posedge clk) disable iff (rst)
        win_overflow |-> (cwp == $past(cwp)));

    // R8: a refused restore leaves the pointer in place
    assert_no_underflow_move_R8: assert property (@(posedge clk) disable iff (rst)
        win_underflow |-> (cwp == $past(cwp)));

    // R7: overflow and underflow are never raised together
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({win_overflow, win_underflow}));

    // R11: simultaneous strobes are ignored
    assert_both_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (call_save && ret_restore) |=> ($stable(cwp) && !win_overflow && !win_underflow));

endmodule

bind win_regfile wrf_checker #(
    .NWIN (NWIN),
    .XLEN (XLEN),
    .CW   (CW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_a_addr     (rd_a_addr),
    .rd_a_data     (rd_a_data),
    .rd_b_addr     (rd_b_addr),
    .rd_b_data     (rd_b_data),
    .call_save     (call_save),
    .ret_restore   (ret_restore),
    .cwp           (cwp),
    .win_overflow  (win_overflow),
    .win_underflow (win_underflow)
);

// File: tb/win_regfile_tb.sv
`timescale 1ns/1ps
module win_regfile_tb;

    localparam int NW = 4;
    localparam int XL = 32;
    localparam int CWB = $clog2(NW);

    logic            clk = 1'b0;
    logic            rst;
    logic [4:0]      rd_a_addr, rd_b_addr, wr_addr;
    logic [XL-1:0]   rd_a_data, rd_b_data, wr_data;
    logic            wr_en, call_save, ret_restore;
    logic [CWB-1:0]  cwp;
    logic            win_overflow, win_underflow;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // behavioural model: globals plus one frame record per window
    logic [XL-1:0] m_glob [8];
    logic [XL-1:0] m_loc  [NW][8];
    logic [XL-1:0] m_in   [NW][8];
    int m_cwp, m_depth;
    bit m_ovf, m_unf;

    always #5 clk = ~clk;

    win_regfile #(.NWIN(NW), .XLEN(XL)) u_dut (
        .clk(clk), .rst(rst),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .call_save(call_save), .ret_restore(ret_restore),
        .cwp(cwp), .win_overflow(win_overflow), .win_underflow(win_underflow)
    );

    task automatic check(input string req, input logic [XL-1:0] act, input logic [XL-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL [%s] act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // location key: -1 zero, 0..7 global, 100+w*8+k local, 200+w*8+k incoming
    function automatic int m_key(input int a);
        int up;
        if (a == 0) return -1;
        if (a < 8) return a;
        if (a < 16) begin
            up = (m_cwp + NW - 1) % NW;
            return 200 + up * 8 + (a - 8);
        end
        if (a < 24) return 100 + m_cwp * 8 + (a - 16);
        return 200 + m_cwp * 8 + (a - 24);
    endfunction

    function automatic logic [XL-1:0] m_get(input int key);
        if (key < 0) return '0;
        if (key < 100) return m_glob[key];
        if (key < 200) return m_loc[(key - 100) / 8][(key - 100) % 8];
        return m_in[(key - 200) / 8][(key - 200) % 8];
    endfunction

    task automatic m_put(input int key, input logic [XL-1:0] v);
        if (key < 0) return;
        if (key < 100) m_glob[key] = v;
        else if (key < 200) m_loc[(key - 100) / 8][(key - 100) % 8] = v;
        else m_in[(key - 200) / 8][(key - 200) % 8] = v;
    endtask

    function automatic logic [XL-1:0] m_read(input int a);
        int k;
        k = m_key(a);
        if (k >= 0 && wr_en && k == m_key(int'(wr_addr))) return wr_data;
        return m_get(k);
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 8; i++) m_glob[i] = '0;
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 8; i++) begin
                m_loc[w][i] = '0;
                m_in[w][i]  = '0;
            end
        m_cwp = 0; m_depth = 0; m_ovf = 0; m_unf = 0;
    endtask

    // one clock: drive, compare reads, edge, update model, compare state
    task automatic cycle(input string req, input bit sv, input bit rs, input bit we,
                         input int wa, input logic [XL-1:0] wd, input int ra, input int rb);
        call_save = sv; ret_restore = rs; wr_en = we;
        wr_addr = 5'(wa); wr_data = wd; rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
        #1;
        check(req, rd_a_data, m_read(ra));
        check(req, rd_b_data, m_read(rb));
        @(posedge clk);
        if (we) m_put(m_key(wa), wd);
        m_ovf = 0; m_unf = 0;
        if (sv && !rs) begin
            if (m_depth == NW - 2) m_ovf = 1;
            else begin m_cwp = (m_cwp + NW - 1) % NW; m_depth++; end
        end else if (rs && !sv) begin
            if (m_depth == 0) m_unf = 1;
            else begin m_cwp = (m_cwp + 1) % NW; m_depth--; end
        end
        #1;
        check(req, XL'(cwp), XL'(m_cwp));
        check(req, XL'(win_overflow), XL'(m_ovf));
        check(req, XL'(win_underflow), XL'(m_unf));
    endtask

    task automatic rd(input string req, input int a, input logic [XL-1:0] exp);
        cycle(req, 0, 0, 0, 0, '0, a, 0);
        rd_a_addr = 5'(a); #1;
        check(req, rd_a_data, exp);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL [R9] watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; call_save = 0; ret_restore = 0; wr_en = 0;
        wr_addr = '0; wr_data = '0; rd_a_addr = '0; rd_b_addr = '0;
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R9: reset state
        check("R9", XL'(cwp), '0);
        check("R9", XL'(win_overflow), '0);
        for (int a = 0; a < 32; a += 2) cycle("R9", 0, 0, 0, 0, '0, a, a + 1);

        // R2: writes to register 0 dropped, never forwarded
        cycle("R2", 0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0);
        rd("R2", 0, 32'h0);

        // R1: one value into each group of window 0
        cycle("R1", 0, 0, 1, 3,  32'h0000_0033, 3, 0);
        cycle("R1", 0, 0, 1, 9,  32'h0000_0099, 9, 0);
        cycle("R1", 0, 0, 1, 17, 32'h0000_0017, 17, 0);
        cycle("R1", 0, 0, 1, 25, 32'h0000_0025, 25, 0);

        // R4: save, outgoing 1 becomes incoming 1
        cycle("R4", 1, 0, 0, 0, '0, 0, 0);
        check("R4", XL'(cwp), XL'(NW - 1));
        rd("R4", 25, 32'h0000_0099);
        rd("R3", 3, 32'h0000_0033);
        rd("R5", 17, 32'h0);
        cycle("R5", 0, 0, 1, 17, 32'h0000_0071, 0, 0);

        // R6: restore brings back caller view
        cycle("R6", 0, 1, 0, 0, '0, 0, 0);
        check("R6", XL'(cwp), '0);
        rd("R5", 17, 32'h0000_0017);
        rd("R6", 9, 32'h0000_0099);

        // R8: restore with empty stack
        cycle("R8", 0, 1, 0, 0, '0, 0, 0);
        check("R8", XL'(win_underflow), 1);
        check("R8", XL'(cwp), '0);

        // R7: fill to NW-2 frames then one more save
        cycle("R7", 1, 0, 0, 0, '0, 0, 0);
        cycle("R7", 1, 0, 0, 0, '0, 0, 0);
        cycle("R7", 1, 0, 0, 0, '0, 0, 0);
        check("R7", XL'(win_overflow), 1);
        check("R7", XL'(cwp), 2);
        cycle("R7", 0, 0, 0, 0, '0, 0, 0);
        check("R7", XL'(win_overflow), 0);
        cycle("R6", 0, 1, 0, 0, '0, 0, 0);
        cycle("R6", 0, 1, 0, 0, '0, 0, 0);

        // R11: both strobes together
        cycle("R11", 1, 1, 0, 0, '0, 0, 0);
        check("R11", XL'(cwp), '0);

        // R10: same-cycle write/read forwarding
        cycle("R10", 0, 0, 1, 20, 32'h0000_1234, 20, 20);
        check("R10", rd_a_data, 32'h0000_1234);

        // R12: write in the cycle of a save lands in the old window
        cycle("R12", 1, 0, 1, 10, 32'h0000_0AAA, 0, 0);
        rd("R12", 26, 32'h0000_0AAA);
        cycle("R12", 0, 1, 0, 0, '0, 0, 0);

        // R1: long mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 15));
            cycle("R1", r == 0 || r == 2, r == 1 || r == 2, r > 4,
                  int'($urandom_range(0, 31)), $urandom,
                  int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule